// File: doc/BRIEF.md
# Paged pointer-relative address generator

This block forms the effective address for the two-byte memory-reference and memory increment/decrement instructions of a small 8-bit accumulator processor with a 16-bit address space. From the low three opcode bits, the displacement byte, the extension register and the four 16-bit pointer registers, it computes the address in a single combinational pass. It also computes the pointer update that auto-indexed forms need. One pointer slot is the program counter, and the other three are general pointers.

All pointer-plus-offset arithmetic stays inside the 4 KiB page of the base pointer. The upper four address bits pass through unchanged, and carries out of bit 11 are dropped. A displacement byte of 0x80 is an escape: the signed offset is taken from the extension register instead. When the pointer field is nonzero and the auto-index bit is set, the block requests a one-cycle pointer write-back. A negative offset gives a pre-decrement and a zero or positive offset gives a post-increment. The register file around the block commits that write on its next clock edge.

The auto-index bit with the program-counter slot marks an immediate operand. In that case no address is formed and the caller uses the displacement byte as data. The block also presents the program counter value after the displacement fetch, advanced by one with the same page wrap.

Top module: `paged_ea_gen`

## Requirements
- R1: `mode_bits[1:0]` selects the base pointer from `ptr_bank`. Value 0 is the program counter in bits [15:0], value 1 is bits [31:16], value 2 is bits [47:32] and value 3 is bits [63:48].
- R2: Every pointer-plus-offset result equals the base with its low 12 bits replaced by (base[11:0] + offset) modulo 4096. Bits [15:12] of the result equal bits [15:12] of the base.
- R3: When `disp` equals 0x80, the offset is `ext` read as an 8-bit two's-complement value. This holds for `ext` = 0x80 too, which gives -128.
- R4: Any other `disp` value is used directly as an 8-bit two's-complement offset, covering -127 to +127.
- R5: With `mode_bits[2]` = 0 (indexed), `ea` is base plus offset and `wb_en` is 0.
- R6: With `mode_bits[2]` = 1, a nonzero pointer field and a negative offset, `ea` and `wb_val` both equal base plus offset (pre-decrement).
- R7: With `mode_bits[2]` = 1, a nonzero pointer field and an offset of zero or more, `ea` equals the unmodified base and `wb_val` equals base plus offset (post-increment).
- R8: With `mode_bits` = 3'b100, `imm_mode` is 1, `ea` is 0 and `wb_en` is 0.
- R9: `pc_after` is the program counter slot advanced by one inside its 4 KiB page, for every opcode. 0x0FFF becomes 0x0000.
- R10: `wb_en` is 1 only while `issue` is 1 and the mode is auto-indexed. `wb_sel` equals `mode_bits[1:0]`. `wb_val` is 0 whenever `wb_en` is 0. `ea`, `imm_mode` and `pc_after` do not depend on `issue`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| issue | input | 1 | Address phase of a memory instruction is active this cycle |
| mode_bits | input | 3 | Opcode bits [2:0]: auto-index flag and pointer field |
| disp | input | 8 | Displacement byte of the instruction |
| ext | input | 8 | Extension register, used as the offset on the escape value |
| ptr_bank | input | 64 | Four packed 16-bit pointers, slot 0 being the program counter |
| ea | output | 16 | Effective address (0 in immediate mode) |
| imm_mode | output | 1 | Displacement is immediate data; no address formed |
| wb_en | output | 1 | Pointer write-back request for this cycle |
| wb_sel | output | 2 | Index of the pointer to write back |
| wb_val | output | 16 | New pointer value to write back |
| pc_after | output | 16 | Program counter after the displacement fetch |

## Verification
The block holds no state, so any fault in offset selection, base muxing or page arithmetic shows on `ea`, `wb_val` or `pc_after` in the same cycle as the stimulus. A slip in mode decoding shows the same way on `wb_en` and `imm_mode`. The stimulus is aimed at the points where a wrong internal value and a correct one give different port values:
- page-boundary carries and borrows in both directions;
- the escape byte with positive, negative and -128 extension values;
- a zero offset in auto-index mode, which must take the post-increment path;
- `issue` held low while the other inputs stay the same.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  // Addressing form decoded from the auto-index bit, pointer field and offset sign
  typedef enum logic [1:0] {
    EA_INDEXED = 2'd0,
    EA_PREDEC  = 2'd1,
    EA_POSTINC = 2'd2,
    EA_IMMED   = 2'd3
  } ea_mode_e;

endpackage

// File: rtl/ea_offset_sel.sv
module ea_offset_sel #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] disp,
  input  logic [DATA_W-1:0] ext,
  output logic [DATA_W-1:0] off,
  output logic              esc_hit,
  output logic              off_neg
);
  // Escape value: only the sign bit set (the most negative code)
  localparam logic [DATA_W-1:0] ESC_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] pick_offset(
    input logic [DATA_W-1:0] d,
    input logic [DATA_W-1:0] x
  );
    return (d == ESC_CODE) ? x : d;
  endfunction

  always_comb begin
    esc_hit = (disp == ESC_CODE);
    off     = pick_offset(disp, ext);
    off_neg = off[DATA_W-1];
  end
endmodule

// File: rtl/ea_base_mux.sv
module ea_base_mux #(
  parameter int ADDR_W  = 16,
  parameter int NUM_PTR = 4,
  localparam int SEL_W  = $clog2(NUM_PTR)
) (
  input  logic [NUM_PTR*ADDR_W-1:0] ptr_bank,
  input  logic [SEL_W-1:0]          sel,
  output logic [ADDR_W-1:0]         base,
  output logic [ADDR_W-1:0]         pc_val
);
  logic [ADDR_W-1:0] slot [NUM_PTR];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_slot
    assign slot[g] = ptr_bank[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    base = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (sel == SEL_W'(i)) base = slot[i];
    end
  end

  assign pc_val = slot[0];
endmodule

// File: rtl/ea_page_adder.sv
module ea_page_adder #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 12,
  parameter int OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] sum
);
  localparam int EXT_W = PAGE_W - OFF_W;

  // Add a signed offset to the in-page bits; page bits pass through
  function automatic logic [ADDR_W-1:0] page_add(
    input logic [ADDR_W-1:0] b,
    input logic [OFF_W-1:0]  o
  );
    logic [PAGE_W-1:0] low;
    low = b[PAGE_W-1:0] + {{EXT_W{o[OFF_W-1]}}, o};
    return {b[ADDR_W-1:PAGE_W], low};
  endfunction

  assign sum = page_add(base, off);
endmodule

// File: rtl/ea_mode_decode.sv
module ea_mode_decode #(
  parameter int SEL_W = 2
) (
  input  logic                        auto_bit,
  input  logic [SEL_W-1:0]            sel,
  input  logic                        off_neg,
  output ea_gen_pkg::ea_mode_e        mode
);
  import ea_gen_pkg::*;

  always_comb begin
    if (!auto_bit)       mode = EA_INDEXED;
    else if (sel == '0)  mode = EA_IMMED;
    else if (off_neg)    mode = EA_PREDEC;
    else                 mode = EA_POSTINC;
  end
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen #(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 12,
  parameter int DATA_W  = 8,
  parameter int NUM_PTR = 4,
  localparam int SEL_W  = $clog2(NUM_PTR)
) (
  input  logic                      issue,
  input  logic [2:0]                mode_bits,
  input  logic [DATA_W-1:0]         disp,
  input  logic [DATA_W-1:0]         ext,
  input  logic [NUM_PTR*ADDR_W-1:0] ptr_bank,
  output logic [ADDR_W-1:0]         ea,
  output logic                      imm_mode,
  output logic                      wb_en,
  output logic [SEL_W-1:0]          wb_sel,
  output logic [ADDR_W-1:0]         wb_val,
  output logic [ADDR_W-1:0]         pc_after
);
  import ea_gen_pkg::*;

  localparam logic [DATA_W-1:0] ONE_STEP = DATA_W'(1);

  // Named internal events, brought out for the checker
  logic [SEL_W-1:0]  ptr_sel;
  logic [DATA_W-1:0] off;
  logic              esc_hit;
  logic              off_neg;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] pc_val;
  logic [ADDR_W-1:0] sum;
  ea_mode_e          mode;

  assign ptr_sel = mode_bits[SEL_W-1:0];

  ea_offset_sel #(.DATA_W(DATA_W)) u_off (
    .disp    (disp),
    .ext     (ext),
    .off     (off),
    .esc_hit (esc_hit),
    .off_neg (off_neg)
  );

  ea_base_mux #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR)) u_mux (
    .ptr_bank (ptr_bank),
    .sel      (ptr_sel),
    .base     (base),
    .pc_val   (pc_val)
  );

  ea_page_adder #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFF_W(DATA_W)) u_add (
    .base (base),
    .off  (off),
    .sum  (sum)
  );

  ea_page_adder #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFF_W(DATA_W)) u_pcinc (
    .base (pc_val),
    .off  (ONE_STEP),
    .sum  (pc_after)
  );

  ea_mode_decode #(.SEL_W(SEL_W)) u_dec (
    .auto_bit (mode_bits[2]),
    .sel      (ptr_sel),
    .off_neg  (off_neg),
    .mode     (mode)
  );

  always_comb begin
    imm_mode = (mode == EA_IMMED);
    wb_sel   = ptr_sel;
    wb_en    = 1'b0;
    wb_val   = '0;
    unique case (mode)
      EA_INDEXED: ea = sum;
      EA_PREDEC:  ea = sum;
      EA_POSTINC: ea = base;
      default:    ea = '0;
    endcase
    if (issue && (mode == EA_PREDEC || mode == EA_POSTINC)) begin
      wb_en  = 1'b1;
      wb_val = sum;
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 12,
  parameter int DATA_W  = 8,
  parameter int NUM_PTR = 4,
  localparam int SEL_W  = $clog2(NUM_PTR)
) (
  input logic                      issue,
  input logic [2:0]                mode_bits,
  input logic [DATA_W-1:0]         disp,
  input logic [NUM_PTR*ADDR_W-1:0] ptr_bank,
  input logic [ADDR_W-1:0]         ea,
  input logic                      imm_mode,
  input logic                      wb_en,
  input logic [SEL_W-1:0]          wb_sel,
  input logic [ADDR_W-1:0]         wb_val,
  input logic [ADDR_W-1:0]         pc_after,
  input logic                      esc_hit,
  input logic                      off_neg,
  input logic [ADDR_W-1:0]         base
);
  logic [ADDR_W-1:0] pc_slot;
  assign pc_slot = ptr_bank[ADDR_W-1:0];

  always_comb begin
    // R8
    imm_quiet_chk: assert (!imm_mode || (!wb_en && ea == '0))
      else $error("immediate form produced an address or write-back");
    // R10
    wb_gate_chk: assert (issue || !wb_en)
      else $error("write-back requested without issue");
    // R10
    wb_target_chk: assert (!wb_en || wb_sel == mode_bits[SEL_W-1:0])
      else $error("write-back index differs from pointer field");
    // R6
    predec_ea_chk: assert (!(wb_en && off_neg) || ea == wb_val)
      else $error("pre-decrement address differs from new pointer");
    // R7
    postinc_ea_chk: assert (!(wb_en && !off_neg) || ea == base)
      else $error("post-increment address differs from old pointer");
    // R2
    page_ea_chk: assert (imm_mode || ea[ADDR_W-1:PAGE_W] == base[ADDR_W-1:PAGE_W])
      else $error("address left its page");
    // R9
    page_pc_chk: assert (pc_after[ADDR_W-1:PAGE_W] == pc_slot[ADDR_W-1:PAGE_W])
      else $error("program counter left its page");
    // R3
    esc_code_chk: assert (!esc_hit || disp == {1'b1, {(DATA_W-1){1'b0}}})
      else $error("escape flagged on a plain displacement");
  end
endmodule

bind paged_ea_gen ea_gen_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .NUM_PTR(NUM_PTR)
) u_chk (
  .issue     (issue),
  .mode_bits (mode_bits),
  .disp      (disp),
  .ptr_bank  (ptr_bank),
  .ea        (ea),
  .imm_mode  (imm_mode),
  .wb_en     (wb_en),
  .wb_sel    (wb_sel),
  .wb_val    (wb_val),
  .pc_after  (pc_after),
  .esc_hit   (esc_hit),
  .off_neg   (off_neg),
  .base      (base)
);

// File: tb/sim_paged_ea_gen.sv
module sim_paged_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [2:0]  mode_bits = '0;
  logic [7:0]  disp = '0;
  logic [7:0]  ext = '0;
  logic [63:0] ptr_bank = '0;
  logic [15:0] ea, wb_val, pc_after;
  logic        imm_mode, wb_en;
  logic [1:0]  wb_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] ea;
    logic        imm;
    logic        wben;
    logic [1:0]  wbsel;
    logic [15:0] wbval;
    logic [15:0] pca;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  paged_ea_gen u0 (
    .issue(issue), .mode_bits(mode_bits), .disp(disp), .ext(ext),
    .ptr_bank(ptr_bank), .ea(ea), .imm_mode(imm_mode), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_val(wb_val), .pc_after(pc_after)
  );

  // In-page move modelled with whole-number arithmetic
  function automatic int page_move(input int b, input int o);
    return (b / 4096) * 4096 + (((b % 4096) + o + 4096) % 4096);
  endfunction

  task automatic drive(input bit iss, input int mb, input int d, input int x,
                       input int p0, input int p1, input int p2, input int p3,
                       input string tag);
    exp_t e;
    int pv[4];
    int sel, b, raw, o, s;
    bit autob, immb;
    pv[0] = p0; pv[1] = p1; pv[2] = p2; pv[3] = p3;
    sel   = mb % 4;
    b     = pv[sel];
    raw   = (d == 128) ? x : d;
    o     = (raw >= 128) ? raw - 256 : raw;
    s     = page_move(b, o);
    immb  = (mb >= 4) && (sel == 0);
    autob = (mb >= 4) && (sel != 0);
    e.imm   = immb;
    e.ea    = immb ? 16'h0 : ((autob && o >= 0) ? 16'(b) : 16'(s));
    e.wben  = iss && autob;
    e.wbsel = 2'(sel);
    e.wbval = e.wben ? 16'(s) : 16'h0;
    e.pca   = 16'(page_move(p0, 1));
    e.tag   = tag;
    @(negedge clk);
    issue     = iss;
    mode_bits = 3'(mb);
    disp      = 8'(d);
    ext       = 8'(x);
    ptr_bank  = {16'(p3), 16'(p2), 16'(p1), 16'(p0)};
    sb.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per rising edge, inputs having settled at the falling edge
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.tag, "ea", int'(ea), int'(e.ea));
      cmp(e.tag, "imm_mode", int'(imm_mode), int'(e.imm));
      cmp(e.tag, "wb_en", int'(wb_en), int'(e.wben));
      if (e.wben) cmp(e.tag, "wb_sel", int'(wb_sel), int'(e.wbsel));
      cmp(e.tag, "wb_val", int'(wb_val), int'(e.wbval));
      cmp(e.tag, "pc_after", int'(pc_after), int'(e.pca));
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: no issue, all pointers zero
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
    // R1 base selection through every slot
    drive(1, 0, 2, 0, 16'h1100, 16'h2200, 16'h3300, 16'h4400, "R1 slot0");
    drive(1, 1, 2, 0, 16'h1100, 16'h2200, 16'h3300, 16'h4400, "R1 slot1");
    drive(1, 2, 2, 0, 16'h1100, 16'h2200, 16'h3300, 16'h4400, "R1 slot2");
    drive(1, 3, 2, 0, 16'h1100, 16'h2200, 16'h3300, 16'h4400, "R1 slot3");
    // R2 page carry and borrow
    drive(1, 1, 1, 0, 16'h0000, 16'h1FFF, 16'h3000, 0, "R2 carry");
    drive(1, 2, 8'hFF, 0, 16'h0000, 16'h1FFF, 16'h3000, 0, "R2 borrow");
    // R3 escape offsets
    drive(1, 1, 8'h80, 8'h10, 0, 16'h5F00, 0, 0, "R3 esc pos");
    drive(1, 1, 8'h80, 8'hF0, 0, 16'h5005, 0, 0, "R3 esc neg");
    drive(1, 1, 8'h80, 8'h80, 0, 16'h5040, 0, 0, "R3 esc min");
    // R4 plain signed displacement extremes
    drive(1, 3, 8'h7F, 8'h55, 0, 0, 0, 16'h7FA0, "R4 max");
    drive(1, 3, 8'h81, 8'h55, 0, 0, 0, 16'h7010, "R4 min");
    // R5 indexed with negative offset: no write-back
    drive(1, 2, 8'hF8, 0, 0, 0, 16'h9123, 0, "R5 indexed");
    // R6 pre-decrement, including escape with negative ext
    drive(1, 6, 8'hFE, 0, 0, 0, 16'hA001, 0, "R6 predec");
    drive(1, 5, 8'h80, 8'hFC, 0, 16'hB002, 0, 0, "R6 esc predec");
    // R7 post-increment, including zero offset
    drive(1, 7, 8'h05, 0, 0, 0, 0, 16'hCFFD, "R7 postinc");
    drive(1, 7, 8'h00, 0, 0, 0, 0, 16'hC123, "R7 zero");
    // R8 immediate form
    drive(1, 4, 8'h80, 8'h33, 16'h2345, 16'h1111, 0, 0, "R8 immed");
    // R9 PC advance with page wrap
    drive(1, 0, 0, 0, 16'h0FFF, 0, 0, 0, "R9 wrap");
    drive(0, 4, 8'h12, 0, 16'h5ABC, 0, 0, 0, "R9 step");
    // R10 issue low suppresses an auto-index write-back only
    drive(0, 6, 8'hFE, 0, 0, 0, 16'hA001, 0, "R10 no issue");
    drive(0, 5, 8'h03, 0, 0, 16'h0100, 0, 0, "R10 no issue post");
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule